// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block models the read side of a bit-serial configuration memory that can be chained with others of its kind. A fixed bit array, computed at elaboration from a seed parameter, is read one bit per address by an internal address counter. The counter steps on each rising clock edge while the device is selected and its outputs are enabled. The bit at the current address drives a serial data output. A separate enable output stands in for the tri-state driver, so that several devices can share one data line.

A combined reset/output-enable pin controls the read. In one state it holds the counter at zero and turns the data driver off. In the other state it enables the output. Its polarity is set by a parameter. Once the last bit has been read, the device stops its counter and releases the data line. It then pulls its cascade output low, which selects the next device in the chain. That next device starts its own stream on the following bit slot, so the whole chain reads out as one continuous stream.

Top module: `cfg_serial_rom`

## Requirements
- R1: On a rising clock edge where chip select is active (`ce_n` low), the output function is enabled and the last address has not been passed, the address advances by one.
- R2: While the reset function of `rst_oe` is active, the counter is synchronously loaded with zero and `dout_en` is 0.
- R3: With `RST_HIGH`=1 (the default), `rst_oe`=1 means reset and 0 means output enabled. With `RST_HIGH`=0 the meaning is inverted.
- R4: While `ce_n` is high, the counter holds its value on every clock edge and `dout_en` is 0. On reselection, reading resumes at the same address.
- R5: `dout_en` is 1 only when chip select and output enable are both active and the counter has not passed the last address.
- R6: `ce_next_n` goes low only when chip select and output enable are both active and the counter has passed the last address. In every other case it is 1.
- R7: After the last address has been passed, and while output enable stays active, `ce_next_n` follows `ce_n`.
- R8: If output enable goes inactive after the last address, `ce_next_n` goes high and stays high through re-enabling until the memory has again been read past its last address.
- R9: Bit i of the content equals w[15]^w[9]^w[3], where w = (i*40503 + SEED) mod 2^32. `dout` presents the bit at the current address combinationally, so bit 0 is valid right after reset, before any clock edge.
- R10: The last address is DEPTH-1. After DEPTH advancing edges the counter stops. With two devices chained through `ce_next_n`, the shared line carries the first device's DEPTH bits followed immediately by the second device's bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock; the counter steps on its rising edge |
| ce_n | input | 1 | Chip select, active low |
| rst_oe | input | 1 | Combined reset / output-enable pin; polarity set by RST_HIGH |
| dout | output | 1 | Serial data bit at the current address |
| dout_en | output | 1 | High when `dout` should drive the shared data line |
| ce_next_n | output | 1 | Cascade select for the next device, active low |

## Verification
The bench chains two devices of different depth and checks the handover slot. A design whose terminal count is off by one would drop or repeat a bit at the seam, or drive the line from both devices at once. Deselecting the device mid-stream catches a counter that keeps running in standby, because the stream would resume at the wrong bit. Dropping output enable after the last bit checks that the cascade output returns high and stays high after re-enabling; a design that got this wrong would leave the next device selected. An instance with inverted pin polarity checks that reset and enable are not swapped.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
  // Content bit for address idx: three taps of a scrambled address word.
  function automatic logic pattern_bit(input logic [31:0] seed, input int unsigned idx);
    logic [31:0] w;
    w = (32'(idx) * 32'd40503) + seed;
    return w[15] ^ w[9] ^ w[3];
  endfunction
endpackage

// File: rtl/cfg_rom_array.sv
module cfg_rom_array #(
  parameter int unsigned DEPTH = 1024,
  parameter logic [31:0] SEED  = 32'h0000_1234,
  localparam int unsigned AW = $clog2(DEPTH + 1),
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          bit_out
);
  logic [DEPTH-1:0] rom_bits;

  // Content computed at elaboration; a constant vector maps to LUT or block ROM.
  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    assign rom_bits[i] = cfg_rom_pkg::pattern_bit(SEED, i);
  end

  logic [IW-1:0] idx;
  assign idx = IW'(addr);

  always_comb begin
    if (addr < AW'(DEPTH)) bit_out = rom_bits[idx];
    else                   bit_out = 1'b0;
  end
endmodule

// File: rtl/cfg_rom_addr_ctr.sv
module cfg_rom_addr_ctr #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_act,
  input  logic          ce_act,
  input  logic          oe_act,
  output logic [AW-1:0] addr,
  output logic          past_tc
);
  localparam logic [AW-1:0] END_ADDR = AW'(DEPTH);

  assign past_tc = (addr == END_ADDR);

  always_ff @(posedge clk) begin
    if (rst_act)                           addr <= '0;
    else if (ce_act && oe_act && !past_tc) addr <= addr + 1'b1;
  end

  // R1: enabled step advances by exactly one
  p_step_r1: assert property (@(posedge clk) disable iff (rst_act)
    (ce_act && oe_act && !past_tc) |=> (addr == $past(addr) + 1'b1));
  // R2: reset leaves the counter at zero
  p_hold_zero_r2: assert property (@(posedge clk) rst_act |=> (addr == '0));
  // R4: standby freezes the counter
  p_freeze_r4: assert property (@(posedge clk) disable iff (rst_act)
    !ce_act |=> $stable(addr));
  // R10: once past the last address, the counter stays there
  p_stop_r10: assert property (@(posedge clk) disable iff (rst_act)
    past_tc |=> past_tc);
endmodule

// File: rtl/cfg_rom_cascade.sv
module cfg_rom_cascade (
  input  logic clk,
  input  logic ce_act,
  input  logic oe_act,
  input  logic past_tc,
  output logic dout_en,
  output logic ce_next_n
);
  assign dout_en   = ce_act & oe_act & ~past_tc;
  assign ce_next_n = ~(ce_act & oe_act & past_tc);

  // R6: the next device is never selected while this one drives
  p_no_contend_r6: assert property (@(posedge clk) !ce_next_n |-> !dout_en);
  // R8: output enable inactive always releases the cascade
  p_release_r8: assert property (@(posedge clk) !oe_act |-> ce_next_n);
endmodule

// File: rtl/cfg_serial_rom.sv
module cfg_serial_rom #(
  parameter int unsigned DEPTH    = 1024,
  parameter logic [31:0] SEED     = 32'h0000_1234,
  parameter bit          RST_HIGH = 1'b1
) (
  input  logic clk,
  input  logic ce_n,
  input  logic rst_oe,
  output logic dout,
  output logic dout_en,
  output logic ce_next_n
);
  localparam int unsigned AW = $clog2(DEPTH + 1);

  logic          rst_act, oe_act, ce_act, past_tc;
  logic [AW-1:0] addr;

  // R3: pin polarity chosen by parameter
  if (RST_HIGH) begin : g_rst_high
    assign rst_act = rst_oe;
  end else begin : g_rst_low
    assign rst_act = ~rst_oe;
  end
  assign oe_act = ~rst_act;
  assign ce_act = ~ce_n;

  cfg_rom_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk(clk), .rst_act(rst_act), .ce_act(ce_act), .oe_act(oe_act),
    .addr(addr), .past_tc(past_tc)
  );

  cfg_rom_array #(.DEPTH(DEPTH), .SEED(SEED)) u_rom (
    .addr(addr), .bit_out(dout)
  );

  cfg_rom_cascade u_casc (
    .clk(clk), .ce_act(ce_act), .oe_act(oe_act), .past_tc(past_tc),
    .dout_en(dout_en), .ce_next_n(ce_next_n)
  );

  // R5: no drive while deselected or in reset
  p_hiz_r5: assert property (@(posedge clk) (ce_n || rst_act) |-> !dout_en);
endmodule

// File: tb/tb_cfg_serial_rom.sv
module tb_cfg_serial_rom;
  localparam int CLK_PERIOD = 10;
  localparam int DA = 24;
  localparam int DB = 20;
  localparam logic [31:0] SA = 32'h0000_1234;
  localparam logic [31:0] SB = 32'h0BAD_0F0E;

  logic clk = 1'b0;
  logic ce_n = 1'b0, pin = 1'b1, pin_inv = 1'b0;
  logic a_d, a_en, a_ceo_n, b_d, b_en, b_ceo_n, i_d, i_en, i_ceo_n;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_rom #(.DEPTH(DA), .SEED(SA)) dut (
    .clk(clk), .ce_n(ce_n), .rst_oe(pin),
    .dout(a_d), .dout_en(a_en), .ce_next_n(a_ceo_n));
  cfg_serial_rom #(.DEPTH(DB), .SEED(SB)) dut_b (
    .clk(clk), .ce_n(a_ceo_n), .rst_oe(pin),
    .dout(b_d), .dout_en(b_en), .ce_next_n(b_ceo_n));
  cfg_serial_rom #(.DEPTH(DA), .SEED(SA), .RST_HIGH(1'b0)) dut_inv (
    .clk(clk), .ce_n(1'b0), .rst_oe(pin_inv),
    .dout(i_d), .dout_en(i_en), .ce_next_n(i_ceo_n));

  function automatic logic exp_bit(input logic [31:0] seed, input int i);
    logic [31:0] w;
    w = (32'(i) * 32'd40503) + seed;
    return w[15] ^ w[9] ^ w[3];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 pin = 1'b1; ce_n = 1'b0;
    @(posedge clk); @(posedge clk); #1 pin = 1'b0;
  endtask

  task automatic t_reset();
    @(posedge clk); #1 pin = 1'b1; ce_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 a_en in reset", a_en, 1'b0);
    chk("R2 b_en in reset", b_en, 1'b0);
    chk("R6 ceo in reset", a_ceo_n, 1'b1);
  endtask

  task automatic t_chain();
    logic line;
    do_reset();
    for (int k = 0; k < DA + DB; k++) begin
      @(negedge clk);
      chk("R10 single driver", logic'(a_en ^ b_en), 1'b1);
      line = a_en ? a_d : b_d;
      if (k < DA) chk("R9 stream bit A", line, exp_bit(SA, k));
      else        chk("R10 stream bit B", line, exp_bit(SB, k - DA));
      if (k == DA - 1) chk("R6 ceo before tc", a_ceo_n, 1'b1);
      if (k == DA)     chk("R6 ceo past tc", a_ceo_n, 1'b0);
      @(posedge clk);
    end
    @(negedge clk);
    chk("R10 A off at end", a_en, 1'b0);
    chk("R10 B off at end", b_en, 1'b0);
    chk("R10 B ceo at end", b_ceo_n, 1'b0);
  endtask

  task automatic t_standby();
    do_reset();
    repeat (5) @(posedge clk);
    #1 ce_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 en off in standby", a_en, 1'b0);
    chk("R6 ceo high in standby", a_ceo_n, 1'b1);
    @(posedge clk); #1 ce_n = 1'b0;
    @(negedge clk);
    chk("R4 en back", a_en, 1'b1);
    chk("R4 resume addr 5", a_d, exp_bit(SA, 5));
    @(posedge clk);
    @(negedge clk);
    chk("R1 next addr 6", a_d, exp_bit(SA, 6));
  endtask

  task automatic t_follow();
    do_reset();
    repeat (DA) @(posedge clk);
    @(negedge clk);
    chk("R7 ceo low past tc", a_ceo_n, 1'b0);
    #1 ce_n = 1'b1;
    @(negedge clk);
    chk("R7 ceo follows ce high", a_ceo_n, 1'b1);
    chk("R5 no drive past tc", a_en, 1'b0);
    #1 ce_n = 1'b0;
    @(negedge clk);
    chk("R7 ceo follows ce low", a_ceo_n, 1'b0);
  endtask

  task automatic t_oe_drop();
    do_reset();
    repeat (DA + 3) @(posedge clk);
    #1 pin = 1'b1;
    @(negedge clk);
    chk("R8 ceo high on oe drop", a_ceo_n, 1'b1);
    @(posedge clk); #1 pin = 1'b0;
    @(negedge clk);
    chk("R8 ceo stays high", a_ceo_n, 1'b1);
    chk("R2 restart at bit0", a_d, exp_bit(SA, 0));
    chk("R5 A drives again", a_en, 1'b1);
    chk("R8 B released", b_en, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 ceo still high", a_ceo_n, 1'b1);
  endtask

  task automatic t_polarity();
    @(posedge clk); #1 pin_inv = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 low pin resets", i_en, 1'b0);
    @(posedge clk); #1 pin_inv = 1'b1;
    @(negedge clk);
    chk("R3 high pin enables", i_en, 1'b1);
    chk("R3 bit0", i_d, exp_bit(SA, 0));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 bit2", i_d, exp_bit(SA, 2));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_chain();
        t_standby();
        t_follow();
        t_oe_drop();
        t_polarity();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule